// File: doc/BRIEF.md
# Quire-to-Posit Rounding Encoder

This block closes an exact dot-product pipeline. A wide two's-complement fixed-point accumulator (the quire) holds the unrounded sum of posit products. The encoder turns that value into one N-bit posit with a single rounding step. The rounding rule is round-to-nearest, ties to even, applied to the encoded bit string.

The encoder splits off the sign and takes the magnitude. A leading-zero count finds the leading one and yields the scale factor. The scale factor is split into a regime and an exponent field. The regime is written as a run of equal bits, so its length varies with the scale. That moves the point where the fraction is cut, and the guard, LSB and sticky bits are taken at that point. The rounded pattern is negated for a negative quire. Results are clamped to the largest and smallest nonzero posit magnitudes, so the output is never NaR and never zero for a nonzero input.

There is one register stage. A quire accepted with `valid_i` appears on `posit_o` with `valid_o` on the next cycle.

Top module: `qp_quire_to_posit`

## Requirements
- R1: A quire of zero encodes to the all-zero posit.
- R2: A negative quire (MSB set) produces the two's complement of the posit of its magnitude. The largest negative quire is treated as a magnitude of 2^(QW-1).
- R3: The quire value is the quire integer times 2^-QBIAS. The scale factor is the bit position of the magnitude's leading one minus QBIAS. The value 1.0 encodes to 0x40 (N=8, ES=1).
- R4: The low ES bits of the scale factor form the exponent field, and the remaining upper bits form the regime k. A value k >= 0 is written as k+1 ones then a zero. A value k < 0 is written as -k zeros then a one. The exponent follows the regime, and fraction bits fill what remains of the N-1 bits after the sign.
- R5: Rounding adds one to the N-1-bit body when guard AND (LSB OR sticky) holds. The guard is the first bit past the body, and the sticky is the OR of every lower bit, including discarded quire bits. The cut point moves with the regime length.
- R6: A round-up carry propagates through the fraction into the exponent and regime fields.
- R7: A magnitude at or above maxpos (2^((N-2)*2^ES)) yields maxpos (0x7F for N=8). The NaR pattern (MSB set, all others zero) is never produced.
- R8: A nonzero magnitude below minpos (2^-((N-2)*2^ES)) yields minpos (0x01 for N=8). A nonzero quire never yields zero.
- R9: `valid_o` equals `valid_i` delayed by one cycle. `posit_o` updates only for a cycle with `valid_i` high, and holds otherwise.
- R10: While `rst_ni` is low, `valid_o` and `posit_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Quire input is valid |
| quire_i | input | QW | Two's-complement quire, QBIAS fraction bits |
| valid_o | output | 1 | Posit output is valid |
| posit_o | output | N | Rounded posit result |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid timing and the hold of the output between accepted inputs;
- zero mapping to zero;
- the output sign following the quire sign;
- the absence of NaR and of zero for nonzero inputs;
- internal checks that the normalized magnitude has its leading one on top and that rounding never wraps the body.

The exact bit patterns need the bench's vectors. These cover regime-dependent rounding position, ties in both directions, carries into the exponent and regime, and both saturation limits. Only those vectors can show that the fields land in the right place.

// File: rtl/qp_pkg.sv
package qp_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2,
    SAT_ZERO = 2'd3
  } qp_sat_e;
endpackage

// File: rtl/qp_lzc.sv
module qp_lzc #(
  parameter int W  = 56,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) count_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/qp_normalize.sv
module qp_normalize #(
  parameter int QW    = 56,
  parameter int QBIAS = 24,
  parameter int FW    = 8,
  parameter int SW    = 8
) (
  input  logic [QW-1:0]        quire_i,
  output logic                 sign_o,
  output logic                 zero_o,
  output logic signed [SW-1:0] scale_o,
  output logic [FW-1:0]        frac_o,
  output logic                 sticky_o
);
  localparam int LZW = $clog2(QW + 1);

  logic [QW-1:0]  mag;
  logic [QW-1:0]  norm;
  logic [LZW-1:0] lz;

  assign sign_o = quire_i[QW-1];
  assign mag    = sign_o ? (QW'(0) - quire_i) : quire_i;

  qp_lzc #(.W(QW), .CW(LZW)) i_lzc (
    .data_i  (mag),
    .count_o (lz)
  );

  assign zero_o   = (mag == '0);
  assign norm     = mag << lz;
  // hidden bit dropped; fraction window starts just below it
  assign frac_o   = norm[QW-2 -: FW];
  assign sticky_o = |norm[QW-2-FW:0];
  assign scale_o  = SW'(QW - 1 - QBIAS) - SW'({1'b0, lz});

  always_comb begin
    if (!zero_o) begin
      p_norm_msb_r3: assert (norm[QW-1]);
    end
  end
endmodule

// File: rtl/qp_pack_round.sv
module qp_pack_round
  import qp_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int FW = 8,
  parameter int SW = 8
) (
  input  logic                 sign_i,
  input  logic                 zero_i,
  input  logic signed [SW-1:0] scale_i,
  input  logic [FW-1:0]        frac_i,
  input  logic                 sticky_i,
  output logic [N-1:0]         posit_o
);
  localparam int BW    = 2 + ES + FW + N;
  localparam int MAXSC = (N - 2) << ES;
  localparam logic signed [SW-1:0] SC_HI = SW'(MAXSC);
  localparam logic signed [SW-1:0] SC_LO = SW'(-MAXSC);

  logic signed [SW-1:0] k;
  logic [SW-1:0]        sh;
  logic                 rbit;
  logic [BW-1:0]        base;
  logic signed [BW-1:0] shifted;
  logic [N-2:0]         body;
  logic [N-2:0]         rounded;
  logic                 guard, low, up;
  logic [N-1:0]         mag_p;
  qp_sat_e              sat;

  assign k    = scale_i >>> ES;
  assign rbit = ~k[SW-1];
  // run length minus one: k for k>=0, -k-1 for k<0
  assign sh   = k[SW-1] ? ~k : k;

  if (ES > 0) begin : g_exp
    assign base = {rbit, ~rbit, scale_i[ES-1:0], frac_i, {N{1'b0}}};
  end else begin : g_noexp
    assign base = {rbit, ~rbit, frac_i, {N{1'b0}}};
  end

  assign shifted = $signed(base) >>> sh;
  assign body    = shifted[BW-1 -: N-1];
  assign guard   = shifted[BW-N];
  assign low     = |shifted[BW-N-1:0];
  assign up      = guard & (body[0] | low | sticky_i);
  assign rounded = body + (N-1)'(up);

  always_comb begin
    if (zero_i)                sat = SAT_ZERO;
    else if (scale_i >= SC_HI) sat = SAT_HI;
    else if (scale_i <  SC_LO) sat = SAT_LO;
    else                       sat = SAT_NONE;
  end

  always_comb begin
    unique case (sat)
      SAT_ZERO: mag_p = '0;
      SAT_HI:   mag_p = {1'b0, {(N-1){1'b1}}};
      SAT_LO:   mag_p = {{(N-1){1'b0}}, 1'b1};
      default:  mag_p = {1'b0, rounded};
    endcase
  end

  assign posit_o = sign_i ? (N'(0) - mag_p) : mag_p;

  always_comb begin
    if (sat == SAT_NONE) begin
      p_no_wrap_r7: assert (!(up && (body == '1)));
      p_no_underflow_r8: assert (rounded != '0);
    end
  end
endmodule

// File: rtl/qp_quire_to_posit.sv
module qp_quire_to_posit #(
  parameter int N     = 8,
  parameter int ES    = 1,
  parameter int QW    = 56,
  parameter int QBIAS = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [QW-1:0] quire_i,
  output logic          valid_o,
  output logic [N-1:0]  posit_o
);
  localparam int FW  = 2 * (N - 2 - ES);
  localparam int LZW = $clog2(QW + 1);
  localparam int SW  = LZW + 2;

  logic                 sign, zero, sticky;
  logic signed [SW-1:0] scale;
  logic [FW-1:0]        frac;
  logic [N-1:0]         posit_d;

  qp_normalize #(.QW(QW), .QBIAS(QBIAS), .FW(FW), .SW(SW)) i_norm (
    .quire_i  (quire_i),
    .sign_o   (sign),
    .zero_o   (zero),
    .scale_o  (scale),
    .frac_o   (frac),
    .sticky_o (sticky)
  );

  qp_pack_round #(.N(N), .ES(ES), .FW(FW), .SW(SW)) i_pack (
    .sign_i   (sign),
    .zero_i   (zero),
    .scale_i  (scale),
    .frac_i   (frac),
    .sticky_i (sticky),
    .posit_o  (posit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      posit_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) posit_o <= posit_d;
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(posit_o));
  p_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && quire_i == '0) |=> (posit_o == '0));
  p_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && quire_i != '0) |=> (posit_o[N-1] == $past(quire_i[QW-1])));
  p_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && quire_i != '0) |=> (posit_o != '0));
  p_no_nar_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (posit_o != {1'b1, {(N-1){1'b0}}}));
endmodule

// File: tb/test_qp_quire_to_posit.sv
`timescale 1ns/1ps
module test_qp_quire_to_posit;
  localparam int N  = 8;
  localparam int QW = 56;
  localparam int NV = 26;

  // {quire, expected posit}, N=8, ES=1, QBIAS=24
  localparam logic [63:0] VEC [NV] = '{
    {56'h00000000000000, 8'h00},
    {56'h00000001000000, 8'h40},
    {56'h00000001800000, 8'h48},
    {56'h00000002000000, 8'h50},
    {56'h00000004000000, 8'h60},
    {56'h00000000800000, 8'h30},
    {56'h00000000400000, 8'h20},
    {56'h00000001080000, 8'h40},
    {56'h00000001180000, 8'h42},
    {56'h00000001080001, 8'h41},
    {56'h00000004400000, 8'h60},
    {56'h00000004C00000, 8'h62},
    {56'h00000001F80000, 8'h50},
    {56'h00000800000000, 8'h7E},
    {56'h00000BB8000000, 8'h7F},
    {56'h00001000000000, 8'h7F},
    {56'h00100000000000, 8'h7F},
    {56'h7FFFFFFFFFFFFF, 8'h7F},
    {56'h00000000001000, 8'h01},
    {56'h00000000000001, 8'h01},
    {56'h00000000002000, 8'h02},
    {56'hFFFFFFFF000000, 8'hC0},
    {56'hFFFFFFFB400000, 8'h9E},
    {56'h80000000000000, 8'h81},
    {56'hFFFFFFFFFFFFFF, 8'hFF},
    {56'h00000000000800, 8'h01}
  };
  localparam string TAG [NV] = '{
    "R1", "R3", "R4", "R4", "R4", "R4", "R4", "R5", "R5", "R5",
    "R5", "R5", "R6", "R5", "R6", "R7", "R7", "R7", "R8", "R8",
    "R5", "R2", "R2", "R7", "R8", "R8"
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [QW-1:0] quire_i = '0;
  logic          valid_o;
  logic [N-1:0]  posit_o;
  int            n_tests = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  qp_quire_to_posit i_qp_quire_to_posit (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .quire_i (quire_i),
    .valid_o (valid_o),
    .posit_o (posit_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [QW-1:0] q, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    quire_i = q;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R9", N'(valid_o), N'(1'b1));
    check(tag, posit_o, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10", N'(valid_o), '0);
    check("R10", posit_o, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][63:8], VEC[i][7:0], TAG[i]);
    end

    // R9: output holds and valid drops when valid_i is low
    apply(56'h00000004C00000, 8'h62, "R5");
    @(negedge clk);
    quire_i = 56'h00000001000000;
    @(negedge clk);
    check("R9", N'(valid_o), '0);
    check("R9", posit_o, 8'h62);

    // R9: back-to-back inputs, one result per cycle
    @(negedge clk);
    quire_i = 56'h00000000800000;
    valid_i = 1'b1;
    @(negedge clk);
    check("R9", posit_o, 8'h30);
    quire_i = 56'hFFFFFFFF000000;
    @(negedge clk);
    valid_i = 1'b0;
    check("R9", posit_o, 8'hC0);
    check("R9", N'(valid_o), N'(1'b1));

    // R10: reset mid-run clears outputs
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R10", posit_o, '0);
    check("R10", N'(valid_o), '0);
    rst_ni = 1'b1;
    apply(56'h00000002000000, 8'h50, "R4");

    finish_run();
  end

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule